// File: doc/BRIEF.md
# Interrupt Level Priority Resolver

This block decides, once per clock, whether a processor core should see a hard interrupt request for one of fifteen priority levels, and which trap type goes with it. It merges an external level vector with a software interrupt register. The two timer-match bits of that register are not passed through as their own levels; either of them raises level 14 instead. The highest pending level above the core's priority threshold is then picked and encoded as a trap type in the external-interrupt group.

Three conditions keep the request from changing. While a vector interrupt is being delivered, the resolver holds its state, because vector interrupts outrank every leveled one. When the core is already servicing a higher external trap at a nonzero trap level, a lower nested candidate is not raised. When nothing pending is above the threshold, or interrupts are globally disabled, an active request is withdrawn and the trap type returns to zero.

Top module: `irq_level_arbiter`

## Requirements
- R1: A synchronous active-high reset clears `irq_req` to 0 and `irq_tt` to 0.
- R2: The pending mask is `ext_lvl` OR `soft_int` after the two timer-match bits (bit 0 and bit 15 of `soft_int`) are removed, so a software bit 15 alone never raises level 15.
- R3: When bit 0 or bit 15 of `soft_int` is set, level 14 is pending.
- R4: While `vec_busy` is 1, `irq_req` and `irq_tt` keep their values on the next clock.
- R5: When the pending mask, read as an unsigned number, is less than 2 shifted left by `pil_thr`, an active request is withdrawn on the next clock and `irq_tt` becomes 0.
- R6: With `int_en` at 1, the highest set level i with i > `pil_thr` is selected and, one clock later, `irq_req` is 1 and `irq_tt` is 0x40 OR i (levels 1 to 15 give 0x41 to 0x4F).
- R7: When `trap_lvl` is nonzero, `cur_tt` bits [8:4] equal 0x4 and `cur_tt` is greater than the new candidate trap type, the outputs do not change.
- R8: When `int_en` is 0 (and `vec_busy` is 0), `irq_req` is 0 and `irq_tt` is 0 on the next clock.
- R9: With `pil_thr` at 15 no request is ever raised.
- R10: `irq_req` is 1 exactly when `irq_tt` is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_lvl | input | 16 | External interrupt level vector, bit i for level i |
| soft_int | input | 16 | Software interrupt register; bits 0 and 15 are timer-match flags |
| pil_thr | input | 4 | Processor priority threshold |
| int_en | input | 1 | Global interrupt enable |
| trap_lvl | input | 3 | Current trap nesting level |
| cur_tt | input | 9 | Trap type being serviced at the current trap level |
| vec_busy | input | 1 | A vector interrupt is pending delivery |
| irq_req | output | 1 | Hard interrupt request to the core |
| irq_tt | output | 9 | Selected trap type, 0 when no request |

## Verification
Directed patterns separate the merge rules: a software bit 15 alone under threshold 14 tells removal of the timer bit from its folding into level 14, and mixed external and software bits at several thresholds tell the highest-above-threshold pick from an off-by-one at the threshold boundary. Nested patterns put a higher external trap in service and then change `cur_tt` to a non-group value, which separates the group test from a plain magnitude compare. Long random runs with vector-busy, disable and trap-level toggles are compared each clock against a behavioural model, which exposes any wrong hold, withdraw or re-raise ordering.

// File: rtl/irqres_pkg.sv
package irqres_pkg;

  // Compose a trap type from a group base and a level number.
  function automatic int unsigned make_trap_type(input int unsigned base,
                                                 input int unsigned lvl);
    return base | lvl;
  endfunction

  // Threshold bound: a pending mask below this value has nothing above thr.
  function automatic int unsigned thr_bound(input int unsigned thr);
    return 32'd2 << thr;
  endfunction

endpackage

// File: rtl/irqres_pend_merge.sv
module irqres_pend_merge #(
  parameter int LVL_N   = 16,
  parameter int TMR0    = 0,
  parameter int TMR1    = 15,
  parameter int TMR_LVL = 14
) (
  input  logic [LVL_N-1:0] ext_lvl,
  input  logic [LVL_N-1:0] soft_int,
  output logic [LVL_N-1:0] pend,
  output logic             tmr_hit
);
  localparam logic [LVL_N-1:0] TMR_MASK =
    (LVL_N'(1) << TMR0) | (LVL_N'(1) << TMR1);

  logic [LVL_N-1:0] soft_clean;

  assign tmr_hit    = soft_int[TMR0] | soft_int[TMR1];
  assign soft_clean = soft_int & ~TMR_MASK;

  always_comb begin
    pend = ext_lvl | soft_clean;
    if (tmr_hit) pend[TMR_LVL] = 1'b1;
  end
endmodule

// File: rtl/irqres_level_pick.sv
module irqres_level_pick #(
  parameter int LVL_N = 16,
  parameter int THR_W = 4,
  localparam int LW   = $clog2(LVL_N)
) (
  input  logic [LVL_N-1:0] pend,
  input  logic [THR_W-1:0] thr,
  output logic             below,
  output logic             found,
  output logic [LW-1:0]    lvl
);
  logic [LVL_N-1:0] elig;
  logic [LVL_N:0]   bound;

  assign bound = (LVL_N+1)'(irqres_pkg::thr_bound(32'(thr)));
  assign below = {1'b0, pend} < bound;

  for (genvar g = 0; g < LVL_N; g++) begin : g_elig
    assign elig[g] = pend[g] && (g > int'(thr));
  end

  always_comb begin
    found = 1'b0;
    lvl   = '0;
    for (int i = 0; i < LVL_N; i++) begin
      if (elig[i]) begin
        found = 1'b1;
        lvl   = LW'(i);
      end
    end
  end
endmodule

// File: rtl/irqres_nest_guard.sv
module irqres_nest_guard #(
  parameter int TT_W = 9,
  parameter int TL_W = 3,
  parameter int GRP  = 'h40
) (
  input  logic [TL_W-1:0] trap_lvl,
  input  logic [TT_W-1:0] cur_tt,
  input  logic [TT_W-1:0] cand_tt,
  output logic            block
);
  localparam logic [TT_W-1:0] GRP_MASK = TT_W'('h1F0);
  localparam logic [TT_W-1:0] GRP_BASE = TT_W'(GRP);

  logic in_group;

  assign in_group = (cur_tt & GRP_MASK) == GRP_BASE;
  assign block    = (trap_lvl != '0) && in_group && (cur_tt > cand_tt);
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter #(
  parameter int LVL_N   = 16,
  parameter int THR_W   = 4,
  parameter int TL_W    = 3,
  parameter int TT_W    = 9,
  parameter int GRP     = 'h40,
  parameter int TMR0    = 0,
  parameter int TMR1    = 15,
  parameter int TMR_LVL = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_N-1:0] ext_lvl,
  input  logic [LVL_N-1:0] soft_int,
  input  logic [THR_W-1:0] pil_thr,
  input  logic             int_en,
  input  logic [TL_W-1:0]  trap_lvl,
  input  logic [TT_W-1:0]  cur_tt,
  input  logic             vec_busy,
  output logic             irq_req,
  output logic [TT_W-1:0]  irq_tt
);
  localparam int LW = $clog2(LVL_N);

  // named internal events
  logic [LVL_N-1:0] pend_mask;
  logic             tmr_hit;
  logic             below_thr;
  logic             pick_found;
  logic [LW-1:0]    pick_lvl;
  logic [TT_W-1:0]  cand_tt;
  logic             nest_block;
  logic             do_raise;
  logic             do_drop;

  logic             req_q, req_d;
  logic [TT_W-1:0]  tt_q, tt_d;

  irqres_pend_merge #(
    .LVL_N(LVL_N), .TMR0(TMR0), .TMR1(TMR1), .TMR_LVL(TMR_LVL)
  ) u_merge (
    .ext_lvl (ext_lvl),
    .soft_int(soft_int),
    .pend    (pend_mask),
    .tmr_hit (tmr_hit)
  );

  irqres_level_pick #(.LVL_N(LVL_N), .THR_W(THR_W)) u_pick (
    .pend (pend_mask),
    .thr  (pil_thr),
    .below(below_thr),
    .found(pick_found),
    .lvl  (pick_lvl)
  );

  assign cand_tt = TT_W'(irqres_pkg::make_trap_type(GRP, 32'(pick_lvl)));

  irqres_nest_guard #(.TT_W(TT_W), .TL_W(TL_W), .GRP(GRP)) u_guard (
    .trap_lvl(trap_lvl),
    .cur_tt  (cur_tt),
    .cand_tt (cand_tt),
    .block   (nest_block)
  );

  assign do_drop  = !vec_busy && req_q && (below_thr || !int_en);
  assign do_raise = !vec_busy && !below_thr && int_en && pick_found &&
                    !nest_block && (tt_q != cand_tt);

  always_comb begin
    req_d = req_q;
    tt_d  = tt_q;
    if (do_drop) begin
      req_d = 1'b0;
      tt_d  = '0;
    end else if (do_raise) begin
      req_d = 1'b1;
      tt_d  = cand_tt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      tt_q  <= '0;
    end else begin
      req_q <= req_d;
      tt_q  <= tt_d;
    end
  end

  assign irq_req = req_q;
  assign irq_tt  = tt_q;
endmodule

// File: rtl/irq_level_arbiter_chk.sv
module irq_level_arbiter_chk #(
  parameter int THR_W = 4,
  parameter int TT_W  = 9
) (
  input logic             clk,
  input logic             rst,
  input logic [THR_W-1:0] pil_thr,
  input logic             int_en,
  input logic             vec_busy,
  input logic             below_thr,
  input logic             nest_block,
  input logic             irq_req,
  input logic [TT_W-1:0]  irq_tt
);
  localparam logic [THR_W-1:0] THR_TOP = '1;

  a_r4_busy_hold: assert property (@(posedge clk) disable iff (rst)
    vec_busy |=> ($stable(irq_req) && $stable(irq_tt)));

  a_r8_disabled_clear: assert property (@(posedge clk) disable iff (rst)
    (!vec_busy && !int_en) |=> (!irq_req && irq_tt == '0));

  a_r5_below_clear: assert property (@(posedge clk) disable iff (rst)
    (!vec_busy && below_thr) |=> (!irq_req && irq_tt == '0));

  a_r10_req_matches_tt: assert property (@(posedge clk) disable iff (rst)
    irq_req == (irq_tt != '0));

  a_r6_tt_in_group: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_tt[TT_W-1:4] == 'h4 && irq_tt[3:0] != 4'h0));

  a_r6_above_thr: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> (irq_tt[3:0] > 4'($past(pil_thr))));

  a_r9_top_silent: assert property (@(posedge clk) disable iff (rst)
    (!vec_busy && pil_thr == THR_TOP) |=> !irq_req);

  a_r7_nest_hold: assert property (@(posedge clk) disable iff (rst)
    (!vec_busy && int_en && !below_thr && nest_block) |=>
      ($stable(irq_req) && $stable(irq_tt)));
endmodule

bind irq_level_arbiter irq_level_arbiter_chk #(.THR_W(THR_W), .TT_W(TT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pil_thr   (pil_thr),
  .int_en    (int_en),
  .vec_busy  (vec_busy),
  .below_thr (below_thr),
  .nest_block(nest_block),
  .irq_req   (irq_req),
  .irq_tt    (irq_tt)
);

// File: tb/irq_level_arbiter_tb.sv
module irq_level_arbiter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] ext_lvl = '0;
  logic [15:0] soft_int = '0;
  logic [3:0]  pil_thr = '0;
  logic        int_en = 1'b0;
  logic [2:0]  trap_lvl = '0;
  logic [8:0]  cur_tt = '0;
  logic        vec_busy = 1'b0;
  logic        irq_req;
  logic [8:0]  irq_tt;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;
  string tag_now  = "R1";
  string tag_prev = "R1";

  always #5 clk = ~clk;

  irq_level_arbiter u_dut (
    .clk(clk), .rst(rst), .ext_lvl(ext_lvl), .soft_int(soft_int),
    .pil_thr(pil_thr), .int_en(int_en), .trap_lvl(trap_lvl),
    .cur_tt(cur_tt), .vec_busy(vec_busy), .irq_req(irq_req), .irq_tt(irq_tt)
  );

  // behavioural reference model
  bit m_req;
  int m_tt;
  always @(posedge clk) begin
    int p;
    int lvl;
    int cand;
    if (rst) begin
      m_req <= 0;
      m_tt  <= 0;
    end else if (!vec_busy) begin
      p = int'(ext_lvl) & ~32'h8001 | int'(soft_int) & 32'h7FFE | int'(ext_lvl);
      if (soft_int[0] || soft_int[15]) p = p | (1 << 14);
      if (p < (2 << pil_thr)) begin
        if (m_req) begin m_req <= 0; m_tt <= 0; end
      end else if (int_en) begin
        lvl = 0;
        for (int i = 15; i > int'(pil_thr); i--)
          if (((p >> i) & 1) == 1 && lvl == 0) lvl = i;
        cand = 64 + lvl;
        if (trap_lvl > 0 && int'(cur_tt) > cand && (int'(cur_tt) / 16) == 4) begin
        end else if (m_tt != cand) begin
          m_req <= 1;
          m_tt  <= cand;
        end
      end else if (m_req) begin
        m_req <= 0;
        m_tt  <= 0;
      end
    end
  end

  task automatic compare();
    vectors++;
    if (irq_req !== m_req || int'(irq_tt) !== m_tt) begin
      errors++;
      $display("FAIL %s: got req=%0b tt=%h, expected req=%0b tt=%h",
               tag_prev, irq_req, irq_tt, m_req, m_tt[8:0]);
    end
  endtask

  // one cycle: compare last result, then drive new inputs
  task automatic step(input logic [15:0] e, input logic [15:0] s,
                      input logic [3:0] th, input logic en,
                      input logic [2:0] tl, input logic [8:0] ct,
                      input logic busy, input string tag, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      compare();
      ext_lvl = e; soft_int = s; pil_thr = th; int_en = en;
      trap_lvl = tl; cur_tt = ct; vec_busy = busy;
      tag_prev = tag_now;
      tag_now  = tag;
    end
  endtask

  task automatic expect_out(input logic r, input logic [8:0] t, input string tag);
    @(negedge clk);
    vectors++;
    if (irq_req !== r || irq_tt !== t) begin
      errors++;
      $display("FAIL %s: got req=%0b tt=%h, expected req=%0b tt=%h",
               tag, irq_req, irq_tt, r, t);
    end
    tag_prev = tag_now;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    expect_out(1'b0, 9'h000, "R1");
    rst = 1'b0;
    // R6: highest level above threshold
    step(16'h0022, 0, 4'd0, 1, 0, 0, 0, "R6", 3);
    step(16'h8022, 0, 4'd0, 1, 0, 0, 0, "R6", 3);
    step(16'h0030, 0, 4'd3, 1, 0, 0, 0, "R6", 3);
    // R5: nothing above threshold, withdrawn
    step(16'h0030, 0, 4'd5, 1, 0, 0, 0, "R5", 3);
    step(16'h0001, 0, 4'd0, 1, 0, 0, 0, "R5", 3);
    // R2: timer bit 15 is not level 15
    step(0, 16'h8000, 4'd14, 1, 0, 0, 0, "R2", 3);
    step(0, 16'h0208, 4'd0, 1, 0, 0, 0, "R2", 3);
    // R3: timer bit folds into level 14
    step(0, 16'h0001, 4'd13, 1, 0, 0, 0, "R3", 3);
    step(16'h0004, 16'h8000, 4'd0, 1, 0, 0, 0, "R3", 3);
    // R4: vector busy holds state
    step(16'h0000, 0, 4'd0, 1, 0, 0, 1, "R4", 3);
    step(16'h8000, 0, 4'd0, 0, 0, 0, 1, "R4", 3);
    // R7: nested block by higher external trap
    step(16'h0008, 0, 4'd0, 1, 0, 0, 0, "R7", 3);
    step(16'h0088, 0, 4'd0, 1, 3'd1, 9'h04A, 0, "R7", 3);
    step(16'h0088, 0, 4'd0, 1, 3'd1, 9'h02A, 0, "R7", 3);
    step(16'h0088, 0, 4'd0, 1, 3'd0, 9'h04A, 0, "R7", 3);
    // R8: disabled drops request
    step(16'h0088, 0, 4'd0, 0, 0, 0, 0, "R8", 3);
    step(16'h0088, 0, 4'd0, 1, 0, 0, 0, "R8", 2);
    // R9: top threshold never raises
    step(16'hFFFF, 16'hFFFF, 4'd15, 1, 0, 0, 0, "R9", 4);
    // R10 and all rules under random stimulus
    for (int n = 0; n < 3000; n++) begin
      logic [8:0] ct;
      ct = ($urandom_range(0, 1) == 1) ? {5'h04, 4'($urandom)} : 9'($urandom);
      step(16'($urandom) & (($urandom_range(0, 3) == 0) ? 16'hFFFF : 16'h00FF),
           ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'h0,
           4'($urandom_range(0, 15)),
           $urandom_range(0, 7) != 0,
           ($urandom_range(0, 2) == 0) ? 3'd1 : 3'd0,
           ct,
           $urandom_range(0, 7) == 0,
           "R10", 1);
    end
    step(0, 0, 0, 0, 0, 0, 0, "R8", 2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule